// File: doc/BRIEF.md
# Debug monitor control and status register

This block is a 32-bit memory-mapped register for a processor debug unit. Software reads and writes it over a simple register bus. The upper half holds control bits that software can read and write. The lower half holds sticky status flags. Each flag records an event reported by one detector of the debug detection unit. A flag stays set until software writes a zero to its position; a one written there leaves it alone.

Next to the register sits the routing logic for the target's debug events. There are three event sources:
- a transmit-full flag that the debug unit clears, for target-to-host messaging;
- a receive-full flag that the debug unit sets, for host-to-target messaging;
- a trace-buffer almost-full indication.

The control bits decide whether each event is acted on. An event that is acted on goes to one of three places: an internal debug exception, an external interrupt pin for a system interrupt controller, or a request for the core to enter debug state. The trace storage, the detectors and the core itself lie outside the block and appear only as signals.

Top module: `dbg_mon_ctl_reg`

## Requirements
- R1: After a synchronous active-high reset, `rdData` reads 0 and `dbgExc`, `extIrq` and `debugReq` are all 0.
- R2: A write (`wrEn` high) stores `wrData[25:16]` into the control field. The field reads back unchanged on `rdData[25:16]` from the cycle after the write until the next write.
- R3: Bits 31:26 always read 0, whatever was written. Status bits at positions `NUM_DET` through 15 always read 0.
- R4: Status bit i (for i below `NUM_DET`) becomes 1 in the cycle after `detEvent[i]` is high. It stays 1 until a write carries 0 in `wrData[i]`, which clears it. A write carrying 1 in `wrData[i]` has no effect on it.
- R5: If `detEvent[i]` is high in the same cycle as a write that clears bit i, the bit ends up set.
- R6: Bit 25 (external routing) chooses where every debug exception request goes. When it is 1, the request drives `extIrq`. When it is 0, the request drives `dbgExc`. The two outputs are never high together.
- R7: When bit 24 (transmit interrupt enable) is 1, a 1-to-0 change on `txFull` produces a request exactly one cycle long. The request shows in the cycle after the clock edge that first samples `txFull` low. When bit 24 is 0, the change produces no request.
- R8: When bit 22 (receive interrupt enable) is 1, a 0-to-1 change on `rxFull` produces a one-cycle request with the same timing as R7. When bit 22 is 0, the change produces no request. Holding `rxFull` at a steady level produces no further requests.
- R9: When bit 23 (trace-full enable) is 0, `trcAlmostFull` has no effect on `dbgExc`, `extIrq` or `debugReq`.
- R10: When bit 23 is 1 and bit 21 (trace action select) is 0, `debugReq` is high in each cycle after an edge that samples `trcAlmostFull` high.
- R11: When bit 23 is 1 and bit 21 is 1, a 0-to-1 change on `trcAlmostFull` produces a one-cycle exception request with the same timing as R7, and `debugReq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Address-decoded write enable for this register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current register contents |
| detEvent | input | NUM_DET | Event strobes from the detection unit, one per detector |
| txFull | input | 1 | Transmit-full flag from the debug unit |
| rxFull | input | 1 | Receive-full flag from the debug unit |
| trcAlmostFull | input | 1 | Trace-buffer almost-full indication |
| dbgExc | output | 1 | Internal debug exception request |
| extIrq | output | 1 | External interrupt pin request |
| debugReq | output | 1 | Request for the core to enter debug state |

## Verification
The bench builds the block with `NUM_DET` set to 4. That size lets it try every pair of detector set pattern and clear pattern (256 pairs), and it also covers the reads of the unused status positions above bit 3. It writes all 1024 values of the writable control field with changing reserved bits. It also runs every one of the 32 combinations of the five routing and enable bits against transmit, receive and trace events, checking the width of each pulse and which output it appears on.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  // Register layout (behavioural bit positions)
  localparam int REG_W       = 32;
  localparam int STAT_W      = 16;
  localparam int CTRL_LO     = 16;
  localparam int RSV_LO      = 26;
  localparam int CTRL_W      = RSV_LO - CTRL_LO;
  localparam int BIT_ROUTE   = 25;
  localparam int BIT_TXIE    = 24;
  localparam int BIT_TRCEN   = 23;
  localparam int BIT_RXIE    = 22;
  localparam int BIT_TRCMODE = 21;

  // Strobes from control to datapath
  typedef struct packed {
    logic ctrlWr;
    logic statWr;
  } busStrobe_t;

  // Decoded control bits from datapath to control
  typedef struct packed {
    logic routeExt;
    logic txIe;
    logic rxIe;
    logic trcEn;
    logic trcMode;
  } ctlBits_t;
endpackage

// File: rtl/dmc_regfile.sv
module dmc_regfile
  import dmc_pkg::*;
#(
  parameter int NUM_DET = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  busStrobe_t          strb,
  input  logic [REG_W-1:0]    wrData,
  input  logic [NUM_DET-1:0]  detEvent,
  output logic [REG_W-1:0]    rdData,
  output ctlBits_t            ctl
);
  logic [CTRL_W-1:0]  ctrlQ;
  logic [NUM_DET-1:0] statQ;

  // Control field: plain read/write storage
  always_ff @(posedge clk) begin
    if (rst)              ctrlQ <= '0;
    else if (strb.ctrlWr) ctrlQ <= wrData[RSV_LO-1:CTRL_LO];
  end

  // Sticky flags: set by event, cleared by writing zero; set wins
  for (genvar i = 0; i < NUM_DET; i++) begin : gStat
    logic clrHit;
    assign clrHit = strb.statWr & ~wrData[i];
    always_ff @(posedge clk) begin
      if (rst) statQ[i] <= 1'b0;
      else     statQ[i] <= detEvent[i] | (statQ[i] & ~clrHit);
    end
  end

  always_comb begin
    rdData                       = '0;
    rdData[RSV_LO-1:CTRL_LO]     = ctrlQ;
    rdData[NUM_DET-1:0]          = statQ;
  end

  assign ctl.routeExt = ctrlQ[BIT_ROUTE   - CTRL_LO];
  assign ctl.txIe     = ctrlQ[BIT_TXIE    - CTRL_LO];
  assign ctl.rxIe     = ctrlQ[BIT_RXIE    - CTRL_LO];
  assign ctl.trcEn    = ctrlQ[BIT_TRCEN   - CTRL_LO];
  assign ctl.trcMode  = ctrlQ[BIT_TRCMODE - CTRL_LO];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  ctlBits_t   ctl,
  input  logic       txFull,
  input  logic       rxFull,
  input  logic       trcAlmostFull,
  output busStrobe_t strb,
  output logic       dbgExc,
  output logic       extIrq,
  output logic       debugReq
);
  logic txPrev, rxPrev, trcPrev;
  logic txFall, rxRise, trcRise, excAny;

  assign strb.ctrlWr = wrEn;
  assign strb.statWr = wrEn;

  always_comb begin
    txFall  = ctl.txIe & txPrev & ~txFull;
    rxRise  = ctl.rxIe & ~rxPrev & rxFull;
    trcRise = ctl.trcEn & ctl.trcMode & ~trcPrev & trcAlmostFull;
    excAny  = txFall | rxRise | trcRise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txPrev   <= 1'b0;
      rxPrev   <= 1'b0;
      trcPrev  <= 1'b0;
      dbgExc   <= 1'b0;
      extIrq   <= 1'b0;
      debugReq <= 1'b0;
    end else begin
      txPrev   <= txFull;
      rxPrev   <= rxFull;
      trcPrev  <= trcAlmostFull;
      dbgExc   <= excAny & ~ctl.routeExt;
      extIrq   <= excAny & ctl.routeExt;
      debugReq <= ctl.trcEn & ~ctl.trcMode & trcAlmostFull;
    end
  end
endmodule

// File: rtl/dbg_mon_ctl_reg.sv
module dbg_mon_ctl_reg
  import dmc_pkg::*;
#(
  parameter int NUM_DET = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_DET-1:0] detEvent,
  input  logic               txFull,
  input  logic               rxFull,
  input  logic               trcAlmostFull,
  output logic               dbgExc,
  output logic               extIrq,
  output logic               debugReq
);
  busStrobe_t strb;
  ctlBits_t   ctl;

  dmc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .ctl(ctl),
    .txFull(txFull), .rxFull(rxFull), .trcAlmostFull(trcAlmostFull),
    .strb(strb), .dbgExc(dbgExc), .extIrq(extIrq), .debugReq(debugReq)
  );

  dmc_regfile #(.NUM_DET(NUM_DET)) u_regs (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .detEvent(detEvent), .rdData(rdData), .ctl(ctl)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int NUM_DET = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wrEn,
  input logic [31:0]        wrData,
  input logic [31:0]        rdData,
  input logic [NUM_DET-1:0] detEvent,
  input logic               trcAlmostFull,
  input logic               dbgExc,
  input logic               extIrq,
  input logic               debugReq
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdData[31:26] == 6'd0); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rdData[0] && !(wrEn && !wrData[0])) |=> rdData[0]); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    detEvent[0] |=> rdData[0]); // R5

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dbgExc && extIrq)); // R6

  AST_ROUTE_SEL: assert property (@(posedge clk) disable iff (rst)
    (dbgExc || extIrq) |-> (extIrq == $past(rdData[25]))); // R6

  AST_DBGREQ_GATE: assert property (@(posedge clk) disable iff (rst)
    debugReq |-> $past(trcAlmostFull && rdData[23] && !rdData[21])); // R10
endmodule

bind dbg_mon_ctl_reg dmc_checker #(.NUM_DET(NUM_DET)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .detEvent(detEvent), .trcAlmostFull(trcAlmostFull),
  .dbgExc(dbgExc), .extIrq(extIrq), .debugReq(debugReq)
);

// File: tb/sim_dbg_mon_ctl_reg.sv
`timescale 1ns/1ps
module sim_dbg_mon_ctl_reg;
  localparam int ND = 4;
  logic clk = 1'b0;
  logic rst, wrEn, txFull, rxFull, trcAlmostFull;
  logic [31:0] wrData, rdData;
  logic [ND-1:0] detEvent;
  logic dbgExc, extIrq, debugReq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  dbg_mon_ctl_reg #(.NUM_DET(ND)) u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .detEvent(detEvent), .txFull(txFull), .rxFull(rxFull),
    .trcAlmostFull(trcAlmostFull), .dbgExc(dbgExc), .extIrq(extIrq),
    .debugReq(debugReq)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1; wrData = d; tick(); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic chkOut(input logic e, input logic x, input logic q, input string tag);
    chk({29'd0, dbgExc, extIrq, debugReq}, {29'd0, e, x, q}, tag);
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wrEn = 1'b0; wrData = '0; detEvent = '0;
    txFull = 1'b0; rxFull = 1'b0; trcAlmostFull = 1'b0;
    tick(); tick();
    rst = 1'b0;
    chk(rdData, 32'd0, "R1 reset rdData");
    chkOut(1'b0, 1'b0, 1'b0, "R1 reset outputs");

    // R2/R3: every control value, reserved bits toggled, ones to status
    for (int v = 0; v < 1024; v++) begin
      logic [5:0] junk;
      junk = 6'(v * 37 + 5);
      wr({junk, 10'(v), 16'hFFFF});
      chk(rdData, {6'd0, 10'(v), 16'h0000}, "R2 R3 control readback");
    end
    wr(32'd0);

    // R4/R5: every set/clear pair over the detectors
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        wr(32'd0);
        detEvent = 4'(s); tick(); detEvent = '0;
        chk(rdData, 32'(s), "R4 sticky set");
        tick();
        chk(rdData, 32'(s), "R4 sticky hold");
        wr({16'h0, 16'hFFFF ^ 16'(c)});
        chk(rdData, 32'(s & ~c), "R4 R3 clear by zero");
        wr(32'd0);
        detEvent = 4'(c); wrEn = 1'b1; wrData = 32'd0; tick();
        wrEn = 1'b0; detEvent = '0;
        chk(rdData, 32'(c), "R5 set wins over clear");
      end
    end
    wr(32'd0);

    // R6..R11: all routing/enable combinations
    for (int m = 0; m < 32; m++) begin
      logic rt, tie, rie, ten, tmd, rx, tx;
      rt = m[4]; tie = m[3]; rie = m[2]; ten = m[1]; tmd = m[0];
      wr({6'd0, rt, tie, ten, rie, tmd, 5'd0, 16'd0});
      // transmit: rising edge must not trigger, falling must
      txFull = 1'b1; tick();
      chkOut(1'b0, 1'b0, 1'b0, "R7 tx rise ignored");
      txFull = 1'b0; tick();
      tx = tie;
      chkOut(tx & ~rt, tx & rt, 1'b0, "R6 R7 tx fall request");
      tick();
      chkOut(1'b0, 1'b0, 1'b0, "R7 tx single pulse");
      // receive
      rxFull = 1'b1; tick();
      rx = rie;
      chkOut(rx & ~rt, rx & rt, 1'b0, "R6 R8 rx rise request");
      tick();
      chkOut(1'b0, 1'b0, 1'b0, "R8 rx steady no repeat");
      rxFull = 1'b0; tick();
      chkOut(1'b0, 1'b0, 1'b0, "R8 rx fall ignored");
      // trace almost-full
      trcAlmostFull = 1'b1; tick();
      if (!ten) chkOut(1'b0, 1'b0, 1'b0, "R9 trace disabled");
      else if (!tmd) chkOut(1'b0, 1'b0, 1'b1, "R10 debug entry");
      else chkOut(~rt, rt, 1'b0, "R11 R6 trace exception");
      tick();
      chkOut(1'b0, 1'b0, ten & ~tmd, "R10 R11 trace steady");
      trcAlmostFull = 1'b0; tick();
      chkOut(1'b0, 1'b0, 1'b0, "R9 R10 trace released");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule